// File: doc/BRIEF.md
# Rail Power-Good Supervisor

This block watches a small group of regulator rails and decides, in logic, whether each one is healthy. Every rail delivers two raw comparator levels: one set while the output sits below its undervoltage threshold, one set while it sits above its overvoltage threshold. The rail also has an enable and a per-rail strict-mode bit. Each comparator level is filtered against a minimum persistence time. The time depends on the strict bit and on which way the rail is moving. The filtered result is a per-rail good status.

All durations are counted on a single-cycle tick input that arrives once per microsecond. When a rail is switched on, and again whenever its voltage setting is rewritten, a start-up window opens. If the rail is still not good when that window closes, the block records a fault. A confirmed overvoltage in strict mode also records a fault. Faults stay latched per rail until software clears them, and unmasked faults drive a level interrupt.

The good statuses of all enabled rails are merged into one power-good output. That output is released only after a programmable hold-off and is withdrawn at once when any enabled rail turns bad.

Top module: `pgood_supervisor`

## Requirements
- R1: While reset is held, and in the first cycle after it, every rail_good bit, pg_out, every fault_flag bit and irq are 0.
- R2: With strict mode off, a good rail turns not good only after uv_det has been 1 on UV_NORM_T consecutive ticks (1000 by default, 1 ms). Any cycle with uv_det at 0 restarts the count, so a shorter undervoltage pulse has no effect on rail_good.
- R3: With strict mode on, the undervoltage persistence needed to turn a rail not good is UV_STRICT_T ticks (50 by default).
- R4: A not-good enabled rail turns good after uv_det has been 0 on RISE_T consecutive ticks (10 by default), whatever the strict bit.
- R5: In strict mode, ov_det held 1 on OV_T consecutive ticks (50 by default) forces rail_good to 0 for as long as ov_det stays 1, and sets that rail's fault flag. With strict mode off, ov_det is ignored.
- R6: A start-up window of TIMEOUT_T ticks (5000 by default) opens on the rising edge of a rail's enable, and opens afresh on every vset_wr pulse for that rail. If the rail is not good on the tick that closes the window, its fault flag is set.
- R7: pg_out rises only after the merged status has stayed good for a hold-off selected by pg_dly_sel. Code 0 gives 10000 ticks, code 1 gives 20000, code 2 gives 50000 and code 3 gives 150000.
- R8: pg_out falls in the same cycle that any enabled rail's rail_good falls, with no hold-off.
- R9: A disabled rail reads not good, has its filters and start-up window cleared, and takes no part in the merged status. At least one rail must be enabled for pg_out to be 1.
- R10: A fault flag stays set until a one-cycle flag_clr pulse for that rail. A new fault in the same cycle as the clear wins.
- R11: irq is 1 exactly when some fault_flag bit is set whose int_mask bit is 0.
- R12: Every persistence and hold-off count advances only in cycles where tick is 1. Without ticks, no rail_good or pg_out change is caused by time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | One-cycle timebase strobe, 1 µs apart |
| rail_en | input | NRAILS | Per-rail enable |
| uv_det | input | NRAILS | Raw undervoltage comparator, 1 = below threshold |
| ov_det | input | NRAILS | Raw overvoltage comparator, 1 = above threshold |
| strict_mode | input | NRAILS | Per-rail strict supervision select |
| vset_wr | input | NRAILS | One-cycle pulse: voltage setting of the rail rewritten |
| pg_dly_sel | input | 2 | Power-good hold-off code |
| int_mask | input | NRAILS | 1 = fault of that rail kept off irq |
| flag_clr | input | NRAILS | One-cycle clear of the rail's fault flag |
| rail_good | output | NRAILS | Filtered per-rail good status |
| pg_out | output | 1 | Merged power-good |
| fault_flag | output | NRAILS | Sticky per-rail fault flags |
| irq | output | 1 | Level interrupt |

## Verification
A persistence counter that is off by one, or that is not cleared by a short opposite pulse, moves the rail_good edge by one tick. The bench sees this at the next falling clock edge, because it compares rail_good against an independent model in every cycle. A start-up window that is not reopened shows up as a fault_flag set one window too early. A wrong hold-off lookup moves the pg_out rising edge by thousands of cycles at default scale; with the bench's reduced durations, it moves by a few ticks. pg_out that falls late, or an irq that ignores a mask, differs from the model within one cycle.

// File: rtl/pgs_pkg.sv
// Shared types and helpers for the rail power-good supervisor.
// Assumes: nothing beyond IEEE 1800-2017 elaboration-time functions.
package pgs_pkg;

    // Power-good hold-off code, as presented on pg_dly_sel.
    typedef enum logic [1:0] {
        PGD_SHORT = 2'd0,
        PGD_MID   = 2'd1,
        PGD_LONG  = 2'd2,
        PGD_MAX   = 2'd3
    } pg_delay_e;

    // Largest of three counts, used to size shared counters.
    function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                         input int unsigned c);
        int unsigned m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/rail_monitor.sv
// One rail's supervisor: filters the undervoltage and overvoltage levels
// into a good status and runs the start-up window that turns a late rail
// into a fault pulse.
// Assumes: tick is a single-cycle strobe; every duration parameter >= 1 and
// TIMEOUT_T >= 2; vset_wr is ignored while the rail is disabled.
module rail_monitor #(
    parameter int unsigned UV_NORM_T   = 1000,
    parameter int unsigned UV_STRICT_T = 50,
    parameter int unsigned RISE_T      = 10,
    parameter int unsigned OV_T        = 50,
    parameter int unsigned TIMEOUT_T   = 5000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic en,
    input  logic uv,
    input  logic ov,
    input  logic strict,
    input  logic vset_wr,
    output logic good,
    output logic fault_evt
);
    import pgs_pkg::*;

    localparam int unsigned DG_MAX = max3(UV_NORM_T, UV_STRICT_T, RISE_T);
    localparam int DW = $clog2(DG_MAX + 1);
    localparam int OW = $clog2(OV_T + 1);
    localparam int TW = $clog2(TIMEOUT_T + 1);
    localparam logic [DW-1:0] LIM_UVN  = DW'(UV_NORM_T);
    localparam logic [DW-1:0] LIM_UVS  = DW'(UV_STRICT_T);
    localparam logic [DW-1:0] LIM_RISE = DW'(RISE_T);
    localparam logic [OW-1:0] OV_FULL  = OW'(OV_T);
    localparam logic [TW-1:0] TO_LAST  = TW'(TIMEOUT_T - 1);

    logic          lvl_ok;     // debounced undervoltage state, 1 = above threshold
    logic [DW-1:0] dg_cnt;
    logic [DW-1:0] dg_lim;
    logic          opposing;
    logic [OW-1:0] ov_cnt;
    logic          ov_on;
    logic          en_d;
    logic          armed;
    logic [TW-1:0] to_cnt;
    logic          arm_now;
    logic          ov_evt;
    logic          to_evt;

    // Persistence needed to flip the state depends on direction and mode.
    always_comb begin
        if (!lvl_ok) dg_lim = LIM_RISE;
        else         dg_lim = strict ? LIM_UVS : LIM_UVN;
    end

    assign opposing = lvl_ok ? uv : ~uv;
    assign ov_on    = strict & ov;
    assign arm_now  = (en & ~en_d) | (en & vset_wr);
    assign good     = lvl_ok & (ov_cnt != OV_FULL);

    // Undervoltage filter: count ticks of the opposing level, flip at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            lvl_ok <= 1'b0;
            dg_cnt <= '0;
        end else if (!opposing) begin
            dg_cnt <= '0;
        end else if (tick) begin
            if (dg_cnt >= dg_lim - 1'b1) begin
                lvl_ok <= ~lvl_ok;
                dg_cnt <= '0;
            end else begin
                dg_cnt <= dg_cnt + 1'b1;
            end
        end
    end

    // Overvoltage filter: saturating tick count while strict and above threshold.
    always_ff @(posedge clk) begin
        if (!rst_n || !en || !ov_on) ov_cnt <= '0;
        else if (tick && ov_cnt != OV_FULL) ov_cnt <= ov_cnt + 1'b1;
    end

    // Enable history for rising-edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) en_d <= 1'b0;
        else        en_d <= en;
    end

    // Start-up window: re-armed on enable or voltage write, closes after TIMEOUT_T ticks.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            armed  <= 1'b0;
            to_cnt <= '0;
        end else if (arm_now) begin
            armed  <= 1'b1;
            to_cnt <= '0;
        end else if (armed && tick) begin
            if (to_cnt == TO_LAST) armed <= 1'b0;
            else                   to_cnt <= to_cnt + 1'b1;
        end
    end

    assign ov_evt    = en & ov_on & tick & (ov_cnt == OV_FULL - 1'b1);
    assign to_evt    = en & armed & ~arm_now & tick & (to_cnt == TO_LAST) & ~good;
    assign fault_evt = ov_evt | to_evt;

endmodule

// File: rtl/pg_combiner.sv
// Merges the enabled rails' good statuses into one power-good output,
// with a coded hold-off on release and no delay on withdrawal.
// Assumes: each hold-off count >= 1; tick is a single-cycle strobe.
module pg_combiner #(
    parameter int unsigned NRAILS = 4,
    parameter int unsigned DLY0_T = 10000,
    parameter int unsigned DLY1_T = 20000,
    parameter int unsigned DLY2_T = 50000,
    parameter int unsigned DLY3_T = 150000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic [NRAILS-1:0] rail_en,
    input  logic [NRAILS-1:0] rail_good,
    input  logic [1:0]        dly_sel,
    output logic              pg_out
);
    import pgs_pkg::*;

    localparam int unsigned DMAX = (max3(DLY0_T, DLY1_T, DLY2_T) > DLY3_T)
                                   ? max3(DLY0_T, DLY1_T, DLY2_T) : DLY3_T;
    localparam int CW = $clog2(DMAX + 1);

    logic          all_good;
    logic          pg_q;
    logic [CW-1:0] hold_cnt;
    logic [CW-1:0] hold_lim;

    assign all_good = (|rail_en) & (&(rail_good | ~rail_en));

    // Hold-off length for the selected code.
    always_comb begin
        unique case (pg_delay_e'(dly_sel))
            PGD_SHORT: hold_lim = CW'(DLY0_T);
            PGD_MID:   hold_lim = CW'(DLY1_T);
            PGD_LONG:  hold_lim = CW'(DLY2_T);
            default:   hold_lim = CW'(DLY3_T);
        endcase
    end

    // Release counter: restarts whenever the merged status is bad.
    always_ff @(posedge clk) begin
        if (!rst_n || !all_good) begin
            pg_q     <= 1'b0;
            hold_cnt <= '0;
        end else if (!pg_q && tick) begin
            if (hold_cnt >= hold_lim - 1'b1) pg_q <= 1'b1;
            else                             hold_cnt <= hold_cnt + 1'b1;
        end
    end

    assign pg_out = pg_q & all_good;

endmodule

// File: rtl/fault_collector.sv
// Sticky per-rail fault flags with per-rail clear, and the masked interrupt.
// Assumes: a fault pulse coinciding with a clear leaves the flag set.
module fault_collector #(
    parameter int unsigned NRAILS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NRAILS-1:0] fault_evt,
    input  logic [NRAILS-1:0] flag_clr,
    input  logic [NRAILS-1:0] int_mask,
    output logic [NRAILS-1:0] fault_flag,
    output logic              irq
);
    for (genvar g = 0; g < NRAILS; g++) begin : g_flag
        // One sticky flag per rail; set has priority over clear.
        always_ff @(posedge clk) begin
            if (!rst_n)            fault_flag[g] <= 1'b0;
            else if (fault_evt[g]) fault_flag[g] <= 1'b1;
            else if (flag_clr[g])  fault_flag[g] <= 1'b0;
        end
    end

    assign irq = |(fault_flag & ~int_mask);

endmodule

// File: rtl/pgood_supervisor.sv
// Top of the rail power-good supervisor: one rail_monitor per rail, the
// power-good merger and the fault collector. Durations are in ticks.
// Assumes: comparator levels are already synchronous to clk.
module pgood_supervisor #(
    parameter int unsigned NRAILS      = 4,
    parameter int unsigned UV_NORM_T   = 1000,
    parameter int unsigned UV_STRICT_T = 50,
    parameter int unsigned RISE_T      = 10,
    parameter int unsigned OV_T        = 50,
    parameter int unsigned TIMEOUT_T   = 5000,
    parameter int unsigned DLY0_T      = 10000,
    parameter int unsigned DLY1_T      = 20000,
    parameter int unsigned DLY2_T      = 50000,
    parameter int unsigned DLY3_T      = 150000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic [NRAILS-1:0] rail_en,
    input  logic [NRAILS-1:0] uv_det,
    input  logic [NRAILS-1:0] ov_det,
    input  logic [NRAILS-1:0] strict_mode,
    input  logic [NRAILS-1:0] vset_wr,
    input  logic [1:0]        pg_dly_sel,
    input  logic [NRAILS-1:0] int_mask,
    input  logic [NRAILS-1:0] flag_clr,
    output logic [NRAILS-1:0] rail_good,
    output logic              pg_out,
    output logic [NRAILS-1:0] fault_flag,
    output logic              irq
);
    logic [NRAILS-1:0] fault_evt;

    for (genvar g = 0; g < NRAILS; g++) begin : g_rail
        rail_monitor #(
            .UV_NORM_T  (UV_NORM_T),
            .UV_STRICT_T(UV_STRICT_T),
            .RISE_T     (RISE_T),
            .OV_T       (OV_T),
            .TIMEOUT_T  (TIMEOUT_T)
        ) u_mon (
            .clk      (clk),
            .rst_n    (rst_n),
            .tick     (tick),
            .en       (rail_en[g]),
            .uv       (uv_det[g]),
            .ov       (ov_det[g]),
            .strict   (strict_mode[g]),
            .vset_wr  (vset_wr[g]),
            .good     (rail_good[g]),
            .fault_evt(fault_evt[g])
        );
    end

    pg_combiner #(
        .NRAILS(NRAILS),
        .DLY0_T(DLY0_T),
        .DLY1_T(DLY1_T),
        .DLY2_T(DLY2_T),
        .DLY3_T(DLY3_T)
    ) u_comb (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .rail_en  (rail_en),
        .rail_good(rail_good),
        .dly_sel  (pg_dly_sel),
        .pg_out   (pg_out)
    );

    fault_collector #(
        .NRAILS(NRAILS)
    ) u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .fault_evt (fault_evt),
        .flag_clr  (flag_clr),
        .int_mask  (int_mask),
        .fault_flag(fault_flag),
        .irq       (irq)
    );

endmodule

// File: rtl/pgood_supervisor_chk.sv
// Port-level temporal checks for pgood_supervisor, bound to every instance.
// Assumes: the same NRAILS as the bound instance.
module pgood_supervisor_chk #(
    parameter int unsigned NRAILS = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick,
    input logic [NRAILS-1:0] rail_en,
    input logic [NRAILS-1:0] flag_clr,
    input logic [NRAILS-1:0] rail_good,
    input logic              pg_out,
    input logic [NRAILS-1:0] fault_flag
);
    // A power-good release only follows a tick cycle.
    assert_pg_rise_on_tick_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pg_out) |-> $past(tick));

    for (genvar g = 0; g < NRAILS; g++) begin : g_chk
        // Rail disabled in the previous cycle cannot report good.
        assert_disabled_not_good_R9: assert property (@(posedge clk) disable iff (!rst_n)
            !$past(rail_en[g]) |-> !rail_good[g]);

        // An enabled bad rail always withholds power-good.
        assert_bad_rail_blocks_pg_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (rail_en[g] && !rail_good[g]) |-> !pg_out);

        // Flags persist unless cleared.
        assert_flag_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
            (fault_flag[g] && !flag_clr[g]) |=> fault_flag[g]);

        // Faults are only raised for a rail that was enabled.
        assert_fault_needs_enable_R6: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(fault_flag[g]) |-> $past(rail_en[g]));
    end

endmodule

bind pgood_supervisor pgood_supervisor_chk #(.NRAILS(NRAILS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .rail_en   (rail_en),
    .flag_clr  (flag_clr),
    .rail_good (rail_good),
    .pg_out    (pg_out),
    .fault_flag(fault_flag)
);

// File: tb/sim_pgood_supervisor.sv
`timescale 1ns/1ps
// Bench: behavioural reference model compared every cycle, plus directed checkpoints.
module sim_pgood_supervisor;
    localparam int NR = 3;
    localparam int UVN = 12, UVS = 4, RISE = 3, OVT = 4, TO = 30;
    localparam int D0 = 8, D1 = 12, D2 = 16, D3 = 24;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick = 1'b0;
    logic tick_run = 1'b1;
    logic [NR-1:0] rail_en = '0, uv_det = '1, ov_det = '0, strict_mode = '0;
    logic [NR-1:0] vset_wr = '0, int_mask = '0, flag_clr = '0;
    logic [1:0] pg_dly_sel = 2'd0;
    logic [NR-1:0] rail_good, fault_flag;
    logic pg_out, irq;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    pgood_supervisor #(
        .NRAILS(NR), .UV_NORM_T(UVN), .UV_STRICT_T(UVS), .RISE_T(RISE), .OV_T(OVT),
        .TIMEOUT_T(TO), .DLY0_T(D0), .DLY1_T(D1), .DLY2_T(D2), .DLY3_T(D3)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .tick(tick), .rail_en(rail_en), .uv_det(uv_det),
        .ov_det(ov_det), .strict_mode(strict_mode), .vset_wr(vset_wr),
        .pg_dly_sel(pg_dly_sel), .int_mask(int_mask), .flag_clr(flag_clr),
        .rail_good(rail_good), .pg_out(pg_out), .fault_flag(fault_flag), .irq(irq)
    );

    // ---------------- reference model ----------------
    int  m_state[NR];   // 1 = above undervoltage threshold after filtering
    int  m_run[NR];     // ticks of opposing level seen so far
    int  m_ovt[NR];     // overvoltage ticks seen, saturating at OVT
    int  m_left[NR];    // ticks left in the start-up window, 0 = closed
    bit  m_enp[NR];
    bit  m_flag[NR];
    bit  m_pg;
    int  m_hold;

    function automatic bit m_rgood(int i);
        return (m_state[i] == 1) && (m_ovt[i] < OVT);
    endfunction

    function automatic bit m_merged();
        bit any = 0;
        bit ok = 1;
        for (int i = 0; i < NR; i++) begin
            if (rail_en[i]) begin
                any = 1;
                if (!m_rgood(i)) ok = 0;
            end
        end
        return any && ok;
    endfunction

    function automatic int m_hold_len(logic [1:0] s);
        case (s)
            2'd0: return D0;
            2'd1: return D1;
            2'd2: return D2;
            default: return D3;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NR; i++) begin
                m_state[i] = 0; m_run[i] = 0; m_ovt[i] = 0; m_left[i] = 0;
                m_enp[i] = 0; m_flag[i] = 0;
            end
            m_pg = 0; m_hold = 0;
        end else begin
            bit mg;
            bit ev[NR];
            bit gnow[NR];
            mg = m_merged();
            for (int i = 0; i < NR; i++) gnow[i] = m_rgood(i);
            if (!mg) begin
                m_pg = 0; m_hold = 0;
            end else if (!m_pg && tick) begin
                m_hold++;
                if (m_hold >= m_hold_len(pg_dly_sel)) m_pg = 1;
            end
            for (int i = 0; i < NR; i++) begin
                ev[i] = 0;
                if (!rail_en[i]) begin
                    m_state[i] = 0; m_run[i] = 0; m_ovt[i] = 0; m_left[i] = 0;
                end else begin
                    bit against;
                    int need;
                    against = (m_state[i] == 1) ? uv_det[i] : !uv_det[i];
                    need = (m_state[i] == 0) ? RISE : (strict_mode[i] ? UVS : UVN);
                    if (!against) m_run[i] = 0;
                    else if (tick) begin
                        m_run[i]++;
                        if (m_run[i] >= need) begin
                            m_state[i] = 1 - m_state[i]; m_run[i] = 0;
                        end
                    end
                    if (!(strict_mode[i] && ov_det[i])) m_ovt[i] = 0;
                    else if (tick && m_ovt[i] < OVT) begin
                        m_ovt[i]++;
                        if (m_ovt[i] == OVT) ev[i] = 1;
                    end
                    if (!m_enp[i] || vset_wr[i]) m_left[i] = TO;
                    else if (m_left[i] > 0 && tick) begin
                        m_left[i]--;
                        if (m_left[i] == 0 && !gnow[i]) ev[i] = 1;
                    end
                end
                m_enp[i] = rail_en[i];
                if (ev[i]) m_flag[i] = 1;
                else if (flag_clr[i]) m_flag[i] = 0;
            end
        end
    end

    // ---------------- checking helpers ----------------
    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic compare_model();
        logic [NR-1:0] eg, ef;
        logic ei;
        for (int i = 0; i < NR; i++) begin
            eg[i] = m_rgood(i);
            ef[i] = m_flag[i];
        end
        ei = |(ef & ~int_mask);
        chk("R2/R3/R4/R5/R9 rail_good", int'(rail_good), int'(eg));
        chk("R7/R8/R9 pg_out", int'(pg_out), int'(m_pg && m_merged()));
        chk("R5/R6/R10 fault_flag", int'(fault_flag), int'(ef));
        chk("R11 irq", int'(irq), int'(ei));
    endtask

    // One cycle: compare at the falling edge, then drive the next tick.
    task automatic step(int n = 1);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            if (rst_n) compare_model();
            tick = tick_run && !tick;
            vset_wr = '0;
            flag_clr = '0;
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        #(5.0 * 150000);
        failures++;
        $display("FAIL watchdog expired: actual=running expected=done");
        finish_run();
    end

    initial begin
        // R1: reset state
        step(4);
        chk("R1 rail_good in reset", int'(rail_good), 0);
        chk("R1 pg_out in reset", int'(pg_out), 0);
        chk("R1 fault_flag in reset", int'(fault_flag), 0);
        chk("R1 irq in reset", int'(irq), 0);
        rst_n = 1'b1;
        step(1);
        chk("R1 outputs after release", int'({rail_good, pg_out, fault_flag, irq}), 0);

        // R6: rail stuck low through its start-up window
        rail_en = 3'b001;
        step(80);
        chk("R6 timeout fault", int'(fault_flag[0]), 1);
        chk("R11 irq unmasked", int'(irq), 1);
        int_mask = 3'b001;
        step(1);
        chk("R11 irq masked", int'(irq), 0);
        int_mask = 3'b000;
        step(6);
        chk("R10 flag sticky", int'(fault_flag[0]), 1);
        flag_clr[0] = 1'b1;
        step(2);
        chk("R10 flag cleared", int'(fault_flag[0]), 0);

        // R4 / R7: recovery and release with code 0
        uv_det[0] = 1'b0;
        step(10);
        chk("R4 good after rise filter", int'(rail_good[0]), 1);
        chk("R7 pg held off", int'(pg_out), 0);
        step(20);
        chk("R7 pg released code 0", int'(pg_out), 1);

        // R2: short undervoltage ignored, long one accepted
        uv_det[0] = 1'b1;
        step(16);
        uv_det[0] = 1'b0;
        step(1);
        chk("R2 glitch ignored", int'(rail_good[0]), 1);
        chk("R2 pg kept", int'(pg_out), 1);
        uv_det[0] = 1'b1;
        step(30);
        chk("R2 long undervoltage", int'(rail_good[0]), 0);
        chk("R8 pg withdrawn", int'(pg_out), 0);

        // R3: strict mode uses the short filter
        uv_det[0] = 1'b0;
        step(40);
        strict_mode[0] = 1'b1;
        uv_det[0] = 1'b1;
        step(10);
        chk("R3 strict undervoltage", int'(rail_good[0]), 0);
        uv_det[0] = 1'b0;
        step(40);
        chk("R4 recovery in strict", int'(rail_good[0]), 1);

        // R5: overvoltage only counts in strict mode
        ov_det[0] = 1'b1;
        step(12);
        chk("R5 overvoltage fault", int'(fault_flag[0]), 1);
        chk("R5 overvoltage not good", int'(rail_good[0]), 0);
        ov_det[0] = 1'b0;
        flag_clr[0] = 1'b1;
        step(2);
        strict_mode[0] = 1'b0;
        ov_det[0] = 1'b1;
        step(20);
        chk("R5 overvoltage ignored flag", int'(fault_flag[0]), 0);
        chk("R5 overvoltage ignored good", int'(rail_good[0]), 1);
        ov_det[0] = 1'b0;
        step(30);

        // R12: without ticks nothing times out
        tick_run = 1'b0;
        uv_det[0] = 1'b1;
        step(60);
        chk("R12 no tick no change", int'(rail_good[0]), 1);
        uv_det[0] = 1'b0;
        tick_run = 1'b1;
        step(4);

        // R9: a bad enabled rail blocks pg, disabling it restores pg
        rail_en = 3'b011;
        step(2);
        chk("R8 new bad rail blocks pg", int'(pg_out), 0);
        rail_en = 3'b001;
        step(24);
        chk("R9 disabled rail excluded", int'(pg_out), 1);
        step(80);
        chk("R9 disabled rail no fault", int'(fault_flag[1]), 0);

        // R6: voltage writes reopen the window
        uv_det[2:1] = 2'b00;
        rail_en = 3'b111;
        step(80);
        uv_det[2] = 1'b1;
        vset_wr[2] = 1'b1;
        step(40);
        chk("R6 window still open", int'(fault_flag[2]), 0);
        vset_wr[2] = 1'b1;
        step(40);
        chk("R6 window re-armed", int'(fault_flag[2]), 0);
        step(30);
        chk("R6 fault after write", int'(fault_flag[2]), 1);

        // R7: longest hold-off code
        pg_dly_sel = 2'd3;
        uv_det[2] = 1'b0;
        step(40);
        chk("R7 code 3 still held", int'(pg_out), 0);
        step(30);
        chk("R7 code 3 released", int'(pg_out), 1);
        step(4);
        finish_run();
    end

endmodule